// File: doc/BRIEF.md
# Up/Down Timer with Shadowed Period and Compare

This block is a 16-bit general-purpose timer that serves as a time base for compare and PWM generation. A counter advances on prescaled ticks taken either from the system clock or from rising edges of an external clock pin. It runs in one of several modes: it can stay stopped, count up with a wrap, count up and down in a triangle, or count up and down as a pin on the block sets the direction. The counter's value is compared against an active period and an active compare value. These drive one compare/PWM output with selectable polarity and four sticky event flags behind a mask.

Software writes the period and compare values into shadow copies. While the timer runs, a shadow moves into its active register only at a defined point in the count. That point is the tick that takes the counter to zero, and, if the option is set, also the tick that lands on the period. While the timer is stopped, writes take effect at once. All registers sit behind a small synchronous port: writes land on the clock edge, and reads return combinationally for the address presented.

Top module: `updn_timer`

## Requirements
- R1: After reset every register reads 0, so the timer is stopped, pwmOut is low and irqOut is low.
- R2: Register addresses: 0 control, 1 counter, 2 period (reads active), 3 compare (reads active), 4 flags, 5 mask; reads are combinational. Control fields: bits [1:0] mode (0 stop, 1 up, 2 up/down, 3 pin-directed), [4:2] prescale exponent, bit 5 external clock select, bit 6 also load on period, [8:7] output polarity.
- R3: In up mode each tick adds one, and a tick taken with the counter at or above the active period sets it to 0 instead.
- R4: In up/down mode the counter climbs until it reaches the active period, then falls to 0, then climbs again; the direction flips on the tick taken at the period and on the tick taken at 0.
- R5: In pin-directed mode, dirIn passes through a two-flop synchroniser. High counts up with a wrap to 0 after the period. Low counts down, and a tick taken at 0 loads the period.
- R6: A tick occurs once every 2^N count-clock events, where N is the prescale exponent. Any write to the control register restarts the prescaler.
- R7: With external clock select set, the count-clock events are the rising edges of extClkIn, seen after a two-flop synchroniser.
- R8: While the timer runs, period and compare writes go to shadows. A shadow moves to its active register only on a tick whose new count is 0, or, with bit 6 set, a tick whose new count equals the active period.
- R9: While the timer is stopped, the counter holds and period and compare writes update the active registers on the same edge.
- R10: Flag bits are set on the ticks that produce these new counts: bit 0 zero, bit 1 all ones, bit 2 equal to active compare, bit 3 equal to active period.
- R11: Flags stay set until a 1 is written to their bit at address 4 (a new event wins over the clear). irqOut is high when any flag and its mask bit are both set.
- R12: pwmOut is low for polarity 0 and high for polarity 1. For polarity 2 it is high while counter >= active compare, and polarity 3 is the inverse of polarity 2.
- R13: A counter write takes priority over a tick on the same edge, and that tick raises no flag and moves no shadow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data for regAddr |
| extClkIn | input | 1 | External count clock, asynchronous |
| dirIn | input | 1 | Count direction for pin-directed mode, asynchronous |
| pwmOut | output | 1 | Compare/PWM output |
| irqOut | output | 1 | Masked event request |

## Verification
The embedded properties rely on wrEn, regAddr and wrData being stable around each rising clock edge. They also rely on the control register changing only through a write, so the prescaler restart and the new prescale limit arrive on the same edge. The stimulus changes every synchronous input on the falling edge. Only extClkIn and dirIn toggle freely, because the block synchronises them. Period values are kept small in most random writes so that wraps, reversals and shadow loads happen often. Values near all-ones are written now and then so that the overflow flag is reached.

// File: rtl/updn_timer_pkg.sv
package updn_timer_pkg;

  typedef enum logic [1:0] {
    MODE_STOP = 2'd0,
    MODE_UP   = 2'd1,
    MODE_UPDN = 2'd2,
    MODE_PIN  = 2'd3
  } cntMode_t;

  typedef enum logic [1:0] {
    POL_LOW   = 2'd0,
    POL_HIGH  = 2'd1,
    POL_ACTHI = 2'd2,
    POL_ACTLO = 2'd3
  } outPol_t;

  localparam logic [2:0] ADDR_CTRL    = 3'd0;
  localparam logic [2:0] ADDR_COUNT   = 3'd1;
  localparam logic [2:0] ADDR_PERIOD  = 3'd2;
  localparam logic [2:0] ADDR_COMPARE = 3'd3;
  localparam logic [2:0] ADDR_FLAGS   = 3'd4;
  localparam logic [2:0] ADDR_MASK    = 3'd5;

  localparam int NUM_EVENTS = 4;

  typedef struct packed {
    logic     tick;
    logic     wrCount;
    logic     wrPeriod;
    logic     wrCompare;
    cntMode_t mode;
    logic     loadOnPer;
    outPol_t  pol;
    logic     dirUp;
  } dpCtrl_t;

  typedef struct packed {
    logic evPer;
    logic evCmp;
    logic evMax;
    logic evZero;
  } dpEvents_t;

endpackage

// File: rtl/updn_timer_ctrl.sv
module updn_timer_ctrl
  import updn_timer_pkg::*;
#(
  parameter int W   = 16,
  parameter int PSW = 3,
  parameter int CW  = PSW + 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [2:0]    regAddr,
  input  logic [CW-1:0] wrData,
  input  logic          extClkIn,
  input  logic          dirIn,
  input  dpEvents_t     ev,
  input  logic [W-1:0]  cntQ,
  input  logic [W-1:0]  perQ,
  input  logic [W-1:0]  cmpQ,
  output dpCtrl_t       strb,
  output logic [W-1:0]  rdData,
  output logic          irqOut
);

  localparam int PRE_W = (1 << PSW) - 1;

  logic [CW-1:0]         ctrlReg;
  logic [NUM_EVENTS-1:0] flagQ;
  logic [NUM_EVENTS-1:0] maskQ;
  logic [PRE_W-1:0]      preCnt;
  logic [PRE_W-1:0]      preLimit;
  logic [2:0]            extSync;
  logic [1:0]            dirSync;
  logic                  srcEvent;
  logic                  running;
  logic                  tick;
  logic                  wrCtrl;
  logic                  wrFlags;
  logic                  wrMask;
  logic [PSW-1:0]        psel;
  logic                  clkSel;
  logic [NUM_EVENTS-1:0] evVec;
  logic [NUM_EVENTS-1:0] clrVec;

  assign wrCtrl  = wrEn && (regAddr == ADDR_CTRL);
  assign wrFlags = wrEn && (regAddr == ADDR_FLAGS);
  assign wrMask  = wrEn && (regAddr == ADDR_MASK);

  assign psel     = ctrlReg[PSW+1:2];
  assign clkSel   = ctrlReg[PSW+2];
  assign preLimit = ~({PRE_W{1'b1}} << psel);
  assign running  = (ctrlReg[1:0] != MODE_STOP);
  assign srcEvent = clkSel ? (extSync[1] & ~extSync[2]) : 1'b1;
  assign tick     = running && srcEvent && (preCnt == preLimit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      extSync <= '0;
      dirSync <= '0;
    end else begin
      extSync <= {extSync[1:0], extClkIn};
      dirSync <= {dirSync[0], dirIn};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (wrCtrl) begin
      preCnt <= '0;
    end else if (running && srcEvent) begin
      preCnt <= tick ? '0 : preCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
      maskQ   <= '0;
    end else begin
      if (wrCtrl) ctrlReg <= wrData;
      if (wrMask) maskQ   <= wrData[NUM_EVENTS-1:0];
    end
  end

  assign evVec  = ev;
  assign clrVec = wrFlags ? wrData[NUM_EVENTS-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) flagQ <= '0;
    else       flagQ <= (flagQ & ~clrVec) | evVec;
  end

  always_comb begin
    strb.tick      = tick;
    strb.wrCount   = wrEn && (regAddr == ADDR_COUNT);
    strb.wrPeriod  = wrEn && (regAddr == ADDR_PERIOD);
    strb.wrCompare = wrEn && (regAddr == ADDR_COMPARE);
    strb.mode      = cntMode_t'(ctrlReg[1:0]);
    strb.loadOnPer = ctrlReg[PSW+3];
    strb.pol       = outPol_t'(ctrlReg[PSW+5:PSW+4]);
    strb.dirUp     = dirSync[1];
  end

  always_comb begin
    case (regAddr)
      ADDR_CTRL:    rdData = {{(W-CW){1'b0}}, ctrlReg};
      ADDR_COUNT:   rdData = cntQ;
      ADDR_PERIOD:  rdData = perQ;
      ADDR_COMPARE: rdData = cmpQ;
      ADDR_FLAGS:   rdData = {{(W-NUM_EVENTS){1'b0}}, flagQ};
      ADDR_MASK:    rdData = {{(W-NUM_EVENTS){1'b0}}, maskQ};
      default:      rdData = '0;
    endcase
  end

  assign irqOut = |(flagQ & maskQ);

  AST_PRESCALE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    preCnt <= preLimit); // R6

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !wrFlags |=> ((flagQ & $past(flagQ)) == $past(flagQ))); // R11

  AST_STOPPED_NO_TICK: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> !tick); // R9

endmodule

// File: rtl/updn_timer_dp.sv
module updn_timer_dp
  import updn_timer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  dpCtrl_t      strb,
  input  logic [W-1:0] wrData,
  output logic [W-1:0] cntQ,
  output logic [W-1:0] perQ,
  output logic [W-1:0] cmpQ,
  output dpEvents_t    ev,
  output logic         pwmOut
);

  logic [W-1:0] perSh;
  logic [W-1:0] cmpSh;
  logic [W-1:0] cntNext;
  logic         dirQ;
  logic         dirNext;
  logic         step;
  logic         loadNow;
  logic         stopped;
  logic         rawCmp;

  assign stopped = (strb.mode == MODE_STOP);
  assign step    = strb.tick && !strb.wrCount;

  always_comb begin
    cntNext = cntQ;
    dirNext = dirQ;
    case (strb.mode)
      MODE_UP: begin
        cntNext = (cntQ >= perQ) ? '0 : cntQ + 1'b1;
      end
      MODE_UPDN: begin
        if (dirQ) begin
          if (cntQ >= perQ) begin
            dirNext = 1'b0;
            cntNext = (cntQ == '0) ? '0 : cntQ - 1'b1;
          end else begin
            cntNext = cntQ + 1'b1;
          end
        end else begin
          if (cntQ == '0) begin
            dirNext = 1'b1;
            cntNext = (perQ == '0) ? '0 : {{(W-1){1'b0}}, 1'b1};
          end else begin
            cntNext = cntQ - 1'b1;
          end
        end
      end
      MODE_PIN: begin
        if (strb.dirUp) cntNext = (cntQ >= perQ) ? '0 : cntQ + 1'b1;
        else            cntNext = (cntQ == '0) ? perQ : cntQ - 1'b1;
      end
      default: begin
        cntNext = cntQ;
      end
    endcase
  end

  always_comb begin
    ev.evZero = step && (cntNext == '0);
    ev.evMax  = step && (cntNext == '1);
    ev.evCmp  = step && (cntNext == cmpQ);
    ev.evPer  = step && (cntNext == perQ);
  end

  assign loadNow = step && ((cntNext == '0) || (strb.loadOnPer && (cntNext == perQ)));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '0;
      dirQ <= 1'b0;
    end else begin
      if (strb.wrCount) cntQ <= wrData;
      else if (step)    cntQ <= cntNext;
      if (step) dirQ <= dirNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      perSh <= '0;
      perQ  <= '0;
      cmpSh <= '0;
      cmpQ  <= '0;
    end else begin
      if (strb.wrPeriod) perSh <= wrData;
      if (strb.wrCompare) cmpSh <= wrData;
      if (strb.wrPeriod && stopped) perQ <= wrData;
      else if (loadNow)             perQ <= perSh;
      if (strb.wrCompare && stopped) cmpQ <= wrData;
      else if (loadNow)              cmpQ <= cmpSh;
    end
  end

  assign rawCmp = (cntQ >= cmpQ);

  always_comb begin
    case (strb.pol)
      POL_LOW:   pwmOut = 1'b0;
      POL_HIGH:  pwmOut = 1'b1;
      POL_ACTHI: pwmOut = rawCmp;
      default:   pwmOut = ~rawCmp;
    endcase
  end

  AST_UP_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.mode == MODE_UP && strb.tick && !strb.wrCount && cntQ >= perQ) |=> (cntQ == '0)); // R3

  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (stopped && !strb.wrCount) |=> $stable(cntQ)); // R9

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!stopped && !loadNow) |=> ($stable(perQ) && $stable(cmpQ))); // R8

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrCount |=> (cntQ == $past(wrData))); // R13

endmodule

// File: rtl/updn_timer.sv
module updn_timer
  import updn_timer_pkg::*;
#(
  parameter int W   = 16,
  parameter int PSW = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrEn,
  input  logic [2:0]   regAddr,
  input  logic [W-1:0] wrData,
  output logic [W-1:0] rdData,
  input  logic         extClkIn,
  input  logic         dirIn,
  output logic         pwmOut,
  output logic         irqOut
);

  localparam int CW = PSW + 6;

  dpCtrl_t      strb;
  dpEvents_t    ev;
  logic [W-1:0] cntQ;
  logic [W-1:0] perQ;
  logic [W-1:0] cmpQ;

  updn_timer_ctrl #(.W(W), .PSW(PSW), .CW(CW)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .regAddr  (regAddr),
    .wrData   (wrData[CW-1:0]),
    .extClkIn (extClkIn),
    .dirIn    (dirIn),
    .ev       (ev),
    .cntQ     (cntQ),
    .perQ     (perQ),
    .cmpQ     (cmpQ),
    .strb     (strb),
    .rdData   (rdData),
    .irqOut   (irqOut)
  );

  updn_timer_dp #(.W(W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrData (wrData),
    .cntQ   (cntQ),
    .perQ   (perQ),
    .cmpQ   (cmpQ),
    .ev     (ev),
    .pwmOut (pwmOut)
  );

endmodule

// File: tb/sim_updn_timer.sv
module sim_updn_timer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [15:0] wrData = 16'd0;
  logic [15:0] rdData;
  logic        extClkIn = 1'b0;
  logic        dirIn = 1'b0;
  logic        pwmOut;
  logic        irqOut;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;
  string curTag = "";

  // expected-state model built from the requirements
  logic [8:0]  mCtrl;
  logic [15:0] mCnt, mPerA, mPerS, mCmpA, mCmpS;
  logic        mDir;
  logic [3:0]  mFlags, mMask;
  logic [6:0]  mPre;
  logic [2:0]  mExt;
  logic [1:0]  mDirS;

  always #10 clk = ~clk;

  updn_timer u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .rdData(rdData), .extClkIn(extClkIn), .dirIn(dirIn), .pwmOut(pwmOut), .irqOut(irqOut)
  );

  task automatic modelReset();
    mCtrl = '0; mCnt = '0; mPerA = '0; mPerS = '0; mCmpA = '0; mCmpS = '0;
    mDir = 1'b0; mFlags = '0; mMask = '0; mPre = '0; mExt = '0; mDirS = '0;
  endtask

  task automatic modelStep();
    logic [1:0]  md;
    logic [2:0]  ps;
    logic        src, tick, step, ld, nd;
    logic [6:0]  lim;
    logic [15:0] nx;
    logic [3:0]  ev;
    logic        wCtl, wCnt, wPer, wCmp, wFlg, wMsk;
    md = mCtrl[1:0];
    ps = mCtrl[4:2];
    wCtl = wrEn && regAddr == 3'd0;
    wCnt = wrEn && regAddr == 3'd1;
    wPer = wrEn && regAddr == 3'd2;
    wCmp = wrEn && regAddr == 3'd3;
    wFlg = wrEn && regAddr == 3'd4;
    wMsk = wrEn && regAddr == 3'd5;
    lim = 7'((1 << ps) - 1);
    src = mCtrl[5] ? (mExt[1] & ~mExt[2]) : 1'b1;
    tick = (md != 2'd0) && src && (mPre == lim);
    nx = mCnt;
    nd = mDir;
    if (md == 2'd1) begin
      nx = (mCnt >= mPerA) ? 16'd0 : mCnt + 16'd1;
    end else if (md == 2'd2) begin
      if (mDir) begin
        if (mCnt >= mPerA) begin nd = 1'b0; nx = (mCnt == 0) ? 16'd0 : mCnt - 16'd1; end
        else nx = mCnt + 16'd1;
      end else begin
        if (mCnt == 0) begin nd = 1'b1; nx = (mPerA == 0) ? 16'd0 : 16'd1; end
        else nx = mCnt - 16'd1;
      end
    end else if (md == 2'd3) begin
      if (mDirS[1]) nx = (mCnt >= mPerA) ? 16'd0 : mCnt + 16'd1;
      else          nx = (mCnt == 0) ? mPerA : mCnt - 16'd1;
    end
    step = tick && !wCnt;
    ev = step ? {nx == mPerA, nx == mCmpA, nx == 16'hFFFF, nx == 16'd0} : 4'd0;
    ld = step && (nx == 0 || (mCtrl[6] && nx == mPerA));
    mExt = {mExt[1:0], extClkIn};
    mDirS = {mDirS[0], dirIn};
    if (wCtl) mPre = '0;
    else if (md != 2'd0 && src) mPre = tick ? 7'd0 : mPre + 7'd1;
    if (wCnt) mCnt = wrData;
    else if (step) mCnt = nx;
    if (step) mDir = nd;
    if (ld) begin mPerA = mPerS; mCmpA = mCmpS; end
    if (wPer) begin mPerS = wrData; if (md == 2'd0) mPerA = wrData; end
    if (wCmp) begin mCmpS = wrData; if (md == 2'd0) mCmpA = wrData; end
    mFlags = (mFlags & ~(wFlg ? wrData[3:0] : 4'd0)) | ev;
    if (wMsk) mMask = wrData[3:0];
    if (wCtl) mCtrl = wrData[8:0];
  endtask

  function automatic logic [15:0] modelRead(input logic [2:0] a);
    case (a)
      3'd0: return {7'd0, mCtrl};
      3'd1: return mCnt;
      3'd2: return mPerA;
      3'd3: return mCmpA;
      3'd4: return {12'd0, mFlags};
      3'd5: return {12'd0, mMask};
      default: return 16'd0;
    endcase
  endfunction

  function automatic logic modelPwm();
    case (mCtrl[8:7])
      2'd0: return 1'b0;
      2'd1: return 1'b1;
      2'd2: return mCnt >= mCmpA;
      default: return !(mCnt >= mCmpA);
    endcase
  endfunction

  function automatic string tagFor(input logic [2:0] a);
    case (a)
      3'd1: return "R3";
      3'd2, 3'd3: return "R8";
      3'd4: return "R10";
      3'd5: return "R11";
      default: return "R2";
    endcase
  endfunction

  task automatic expectEq(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // one cycle: model the edge just passed, drive new inputs, compare outputs
  task automatic cyc(input logic we, input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    modelStep();
    wrEn = we;
    regAddr = a;
    wrData = d;
    #1;
    expectEq((curTag.len() != 0) ? curTag : tagFor(a), "rdData", rdData, modelRead(a));
    expectEq((curTag.len() != 0) ? curTag : "R12", "pwmOut", {15'd0, pwmOut}, {15'd0, modelPwm()});
    expectEq((curTag.len() != 0) ? curTag : "R11", "irqOut", {15'd0, irqOut}, {15'd0, |(mFlags & mMask)});
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    modelReset();
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: reset values at every address
    curTag = "R1";
    for (int a = 0; a < 6; a++) begin
      cyc(1'b0, 3'(a), 16'd0);
      expectEq("R1", "reset read", rdData, 16'd0);
    end
    expectEq("R1", "pwmOut reset", {15'd0, pwmOut}, 16'd0);
    expectEq("R1", "irqOut reset", {15'd0, irqOut}, 16'd0);

    // R9: stopped writes land at once
    curTag = "R9";
    cyc(1'b1, 3'd2, 16'd3);
    cyc(1'b0, 3'd2, 16'd0);
    expectEq("R9", "period immediate", rdData, 16'd3);
    cyc(1'b1, 3'd3, 16'd2);
    cyc(1'b0, 3'd3, 16'd0);
    expectEq("R9", "compare immediate", rdData, 16'd2);
    repeat (3) cyc(1'b0, 3'd1, 16'd0);

    // R3: up mode wraps after period 3, active-high output
    curTag = "R3";
    cyc(1'b1, 3'd0, 16'h0101);
    for (int i = 0; i < 8; i++) begin
      cyc(1'b0, 3'd1, 16'd0);
      expectEq("R3", "up count", rdData, 16'(i % 4));
    end

    // R8: shadow writes while running
    curTag = "R8";
    cyc(1'b1, 3'd2, 16'd6);
    cyc(1'b1, 3'd3, 16'd4);
    for (int i = 0; i < 10; i++) cyc(1'b0, 3'(2 + (i % 2)), 16'd0);
    cyc(1'b1, 3'd0, 16'h0141);
    cyc(1'b1, 3'd2, 16'd9);
    for (int i = 0; i < 20; i++) cyc(1'b0, 3'(1 + (i % 3)), 16'd0);

    // R12: all polarities
    curTag = "R12";
    for (int p = 0; p < 4; p++) begin
      cyc(1'b1, 3'd0, 16'(16'h0001 | (p << 7)));
      for (int i = 0; i < 10; i++) cyc(1'b0, 3'd1, 16'd0);
    end

    // R4: up/down triangle
    curTag = "R4";
    cyc(1'b1, 3'd0, 16'h0102);
    for (int i = 0; i < 30; i++) cyc(1'b0, 3'd1, 16'd0);

    // R5: pin-directed counting
    curTag = "R5";
    dirIn = 1'b1;
    cyc(1'b1, 3'd0, 16'h0103);
    for (int i = 0; i < 15; i++) cyc(1'b0, 3'd1, 16'd0);
    dirIn = 1'b0;
    for (int i = 0; i < 20; i++) cyc(1'b0, 3'd1, 16'd0);

    // R6: prescale exponent 2 gives one tick per four clocks
    curTag = "R6";
    cyc(1'b1, 3'd0, 16'h0000);
    cyc(1'b1, 3'd1, 16'd0);
    cyc(1'b1, 3'd2, 16'd100);
    cyc(1'b1, 3'd0, 16'h0009);
    for (int i = 0; i < 12; i++) begin
      cyc(1'b0, 3'd1, 16'd0);
      expectEq("R6", "prescaled count", rdData, 16'(i / 4));
    end

    // R7: external clock edges
    curTag = "R7";
    cyc(1'b1, 3'd0, 16'h0021);
    for (int i = 0; i < 40; i++) begin
      if (i % 3 == 0) extClkIn = ~extClkIn;
      cyc(1'b0, 3'd1, 16'd0);
    end

    // R10: overflow and period events near all-ones
    curTag = "R10";
    cyc(1'b1, 3'd0, 16'h0000);
    cyc(1'b1, 3'd2, 16'hFFFF);
    cyc(1'b1, 3'd3, 16'hFFFE);
    cyc(1'b1, 3'd1, 16'hFFFC);
    cyc(1'b1, 3'd0, 16'h0001);
    for (int i = 0; i < 6; i++) cyc(1'b0, 3'd4, 16'd0);

    // R13: counter write collides with ticks
    curTag = "R13";
    for (int i = 0; i < 6; i++) cyc(1'b1, 3'd1, 16'hFFFF);
    cyc(1'b0, 3'd4, 16'd0);

    // R11: mask and write-one-to-clear
    curTag = "R11";
    cyc(1'b1, 3'd5, 16'h0002);
    cyc(1'b0, 3'd4, 16'd0);
    cyc(1'b1, 3'd4, 16'h0002);
    cyc(1'b0, 3'd4, 16'd0);
    cyc(1'b1, 3'd4, 16'h000F);
    cyc(1'b1, 3'd5, 16'h000F);
    for (int i = 0; i < 8; i++) cyc(1'b0, 3'd4, 16'd0);

    // constrained random mix
    curTag = "";
    for (int k = 0; k < 3000; k++) begin
      logic        we;
      logic [2:0]  a;
      logic [15:0] d;
      if ($urandom % 5 == 0) extClkIn = ~extClkIn;
      if ($urandom % 40 == 0) dirIn = ~dirIn;
      we = ($urandom % 6) == 0;
      a = 3'($urandom % 6);
      case (a)
        3'd0: d = {7'd0, 2'($urandom), 1'($urandom), 1'($urandom % 4 == 0),
                   3'($urandom % 3), 2'($urandom)};
        3'd4, 3'd5: d = 16'($urandom);
        default: d = ($urandom % 8 == 0) ? 16'hFFF8 + 16'($urandom % 8) : 16'($urandom % 24);
      endcase
      cyc(we, a, d);
    end

    done = 1'b1;
    finishRun();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

endmodule